// File: doc/BRIEF.md
# Oversampled Serial Receiver with Majority Vote and Two-Word Buffer

This block receives asynchronous non-return-to-zero serial frames: one low start bit, eight or nine data bits sent least significant bit first, and one high stop bit. An external strobe that pulses sixteen times per bit period paces it. Each bit is measured in the middle of its period. Three consecutive samples are taken, and the bit value is the majority of those three. A single noisy sample therefore cannot corrupt the bit.

When the stop bit has been measured, the finished word enters a two-entry first-in first-out buffer. The word carries its ninth bit and a framing flag with it. The host watches a data-available flag and reads the oldest word by pulsing a read strobe. If a third word completes while both entries are still occupied, the block raises a sticky overrun flag and discards that word. Everything received after that is also discarded until the host drops and raises the receive enable.

Top module: `uart_maj_rx`

## Requirements
- R1: After reset, `data_avail` and `overrun` are both 0.
- R2: In 8-bit mode (`nine_bit_mode`=0), a frame is 1 start bit, 8 data bits sent least significant bit first, and 1 stop bit. The word appears on `rd_data`, and `rd_bit8` reads 0.
- R3: In 9-bit mode (`nine_bit_mode`=1, taken at the start of the frame), the ninth data bit follows bit 7 on the line and appears on `rd_bit8`.
- R4: Bit timing counts `os_tick` pulses, and the tick that detects the falling edge is tick 1 of the start bit. Ticks 7, 8 and 9 of each bit are sampled, and the bit value is the majority of those three samples. One inverted sample among them does not change the received bit.
- R5: In idle, a low sample that follows a high sample begins a frame. If the majority vote of the start bit is high, the frame is abandoned and no word is produced.
- R6: `rd_frame_err` is 1 for a word whose stop-bit vote was low, and 0 otherwise. This flag and `rd_bit8` stay attached to their own word while it waits in the buffer.
- R7: The buffer holds two words and presents them oldest first. `data_avail` is 1 exactly when the buffer is not empty. A `rd_strobe` pulse removes the presented word.
- R8: If a word completes while the buffer holds two words and no read occurs in that cycle, `overrun` becomes 1 and the word is discarded.
- R9: While `overrun` is 1, no completed word enters the buffer, even if the buffer has room.
- R10: While `rx_enable` is 0, `overrun` is cleared, the frame logic is held idle and line activity is ignored. Words already in the buffer remain readable.
- R11: A read in the same cycle as a word's completion frees a place for that word. With a full buffer, the new word is kept and `overrun` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input, idle high |
| rx_enable | input | 1 | Receive enable; 0 resets the receiver and clears overrun |
| nine_bit_mode | input | 1 | 1 selects nine data bits per frame |
| rd_strobe | input | 1 | One-cycle pulse that removes the presented word |
| os_tick | input | 1 | Pulse at sixteen times the bit rate |
| rd_data | output | 8 | Data bits of the oldest buffered word |
| rd_bit8 | output | 1 | Ninth bit of the oldest buffered word |
| rd_frame_err | output | 1 | Framing flag of the oldest buffered word |
| overrun | output | 1 | Sticky overrun flag |
| data_avail | output | 1 | Buffer not empty |

## Verification
The interaction that needs care is a read strobe that coincides with a word's completion while both buffer entries are full. The completion happens on the ninth tick of the stop bit. The bench generates the tick itself, so it raises `rd_strobe` together with that exact tick pulse. The result is correct if `overrun` stays low and the two words then read back are the second and third words of the burst, in that order. The reverse case (the same burst with no read) must set `overrun`, drop the third word, and keep blocking later words until the enable is cycled.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int unsigned RX_DATA_W = 8;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  typedef struct packed {
    logic                 bit8;
    logic                 ferr;
    logic [RX_DATA_W-1:0] data;
  } rx_word_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = din;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS    = 16,
  parameter int unsigned DATA_W = RX_DATA_W
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     tick,
  input  logic     line,
  input  logic     nine_bit,
  output logic     word_done,
  output rx_word_t word
);

  localparam int unsigned CNT_W  = $clog2(OVS + 1);
  localparam int unsigned BIDX_W = $clog2(DATA_W + 1);
  localparam int unsigned MID    = OVS / 2;

  rx_state_e           state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d, num;
  logic [BIDX_W-1:0]   bidx_q, bidx_d, bidx_last;
  logic [1:0]          smp_q, smp_d;
  logic [DATA_W:0]     shift_q, shift_d;
  logic                nine_q, nine_d;
  logic                prev_q, prev_d;
  logic                vote;

  assign num       = (cnt_q == CNT_W'(OVS)) ? CNT_W'(1) : cnt_q + CNT_W'(1);
  assign vote      = (smp_q[0] & smp_q[1]) | (smp_q[0] & line) | (smp_q[1] & line);
  assign bidx_last = nine_q ? BIDX_W'(DATA_W) : BIDX_W'(DATA_W - 1);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    bidx_d    = bidx_q;
    smp_d     = smp_q;
    shift_d   = shift_q;
    nine_d    = nine_q;
    prev_d    = prev_q;
    word_done = 1'b0;
    if (!enable) begin
      state_d = RX_IDLE;
      cnt_d   = '0;
      bidx_d  = '0;
      prev_d  = 1'b1;
    end else if (tick) begin
      if (state_q == RX_IDLE) begin
        prev_d = line;
        if (prev_q && !line) begin
          state_d = RX_START;
          cnt_d   = CNT_W'(1);
          bidx_d  = '0;
          nine_d  = nine_bit;
        end
      end else begin
        cnt_d = num;
        if (num == CNT_W'(MID - 1)) smp_d[0] = line;
        if (num == CNT_W'(MID))     smp_d[1] = line;
        if (num == CNT_W'(MID + 1)) begin
          case (state_q)
            RX_START: if (vote) begin
              state_d = RX_IDLE;
              prev_d  = 1'b1;
            end
            RX_DATA:  shift_d = {vote, shift_q[DATA_W:1]};
            RX_STOP: begin
              word_done = 1'b1;
              prev_d    = vote;
              state_d   = RX_IDLE;
            end
            default: ;
          endcase
        end
        if (num == CNT_W'(OVS)) begin
          if (state_q == RX_START) begin
            state_d = RX_DATA;
            bidx_d  = '0;
          end else if (state_q == RX_DATA) begin
            if (bidx_q == bidx_last) state_d = RX_STOP;
            else                     bidx_d  = bidx_q + BIDX_W'(1);
          end
        end
      end
    end
  end

  always_comb begin
    word.ferr = ~vote;
    if (nine_q) begin
      word.data = shift_q[DATA_W-1:0];
      word.bit8 = shift_q[DATA_W];
    end else begin
      word.data = shift_q[DATA_W:1];
      word.bit8 = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      smp_q   <= '0;
      shift_q <= '0;
      nine_q  <= 1'b0;
      prev_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bidx_q  <= bidx_d;
      smp_q   <= smp_d;
      shift_q <= shift_d;
      nine_q  <= nine_d;
      prev_q  <= prev_d;
    end
  end

  // R5: a frame only completes after passing through the data phase
  assert_stop_from_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_STOP) |-> ($past(state_q) == RX_STOP || $past(state_q) == RX_DATA));

endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  rx_word_t                   push_word,
  input  logic                       pop,
  output rx_word_t                   head,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  rx_word_t          mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign pop_ok = pop && (cnt_q != '0);

  always_comb begin
    wr_d  = push   ? ptr_inc(wr_q) : wr_q;
    rd_d  = pop_ok ? ptr_inc(rd_q) : rd_q;
    cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= push_word;
  end

  assign head  = mem_q[rd_q];
  assign count = cnt_q;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop_ok) |-> (cnt_q < CNT_W'(DEPTH)));

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/uart_maj_rx.sv
module uart_maj_rx
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned FIFO_DEPTH  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_line,
  input  logic                 rx_enable,
  input  logic                 nine_bit_mode,
  input  logic                 rd_strobe,
  input  logic                 os_tick,
  output logic [RX_DATA_W-1:0] rd_data,
  output logic                 rd_bit8,
  output logic                 rd_frame_err,
  output logic                 overrun,
  output logic                 data_avail
);

  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  logic             line_s;
  logic             frame_done;
  rx_word_t         frame_word;
  rx_word_t         head;
  logic [CNT_W-1:0] fifo_cnt;
  logic             pop_now, has_room, push_ok;
  logic             ovr_q, ovr_d;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  rx_frame_fsm #(.OVS(OVS), .DATA_W(RX_DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(rx_enable), .tick(os_tick),
    .line(line_s), .nine_bit(nine_bit_mode),
    .word_done(frame_done), .word(frame_word)
  );

  assign pop_now  = rd_strobe && (fifo_cnt != '0);
  assign has_room = (fifo_cnt < CNT_W'(FIFO_DEPTH)) || pop_now;
  assign push_ok  = frame_done && !ovr_q && has_room;

  always_comb begin
    ovr_d = ovr_q;
    if (!rx_enable)                          ovr_d = 1'b0;
    else if (frame_done && !ovr_q && !has_room) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  rx_word_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .push_word(frame_word),
    .pop(rd_strobe), .head(head), .count(fifo_cnt)
  );

  assign rd_data      = head.data;
  assign rd_bit8      = head.bit8;
  assign rd_frame_err = head.ferr;
  assign overrun      = ovr_q;
  assign data_avail   = (fifo_cnt != '0);

  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(frame_done));

  assert_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> (fifo_cnt <= $past(fifo_cnt)));

  assert_enable_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> !ovr_q);

endmodule

// File: tb/uart_maj_rx_tb.sv
module uart_maj_rx_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_line, rx_enable, nine_bit_mode, rd_strobe, os_tick;
  logic [7:0] rd_data;
  logic       rd_bit8, rd_frame_err, overrun, data_avail;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] m_data [2];
  logic       m_b8   [2];
  logic       m_fe   [2];
  int         m_cnt = 0;
  logic       m_ovr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_maj_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_enable(rx_enable),
    .nine_bit_mode(nine_bit_mode), .rd_strobe(rd_strobe), .os_tick(os_tick),
    .rd_data(rd_data), .rd_bit8(rd_bit8), .rd_frame_err(rd_frame_err),
    .overrun(overrun), .data_avail(data_avail)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_data(input logic [8:0] w);
    return w[7:0];
  endfunction

  function automatic logic exp_b8(input logic [8:0] w, input logic nine);
    return nine ? w[8] : 1'b0;
  endfunction

  // one tick slot: drive line, wait, pulse tick (optionally with a read)
  task automatic slot(input logic lvl, input logic pop);
    @(negedge clk); rx_line = lvl;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); os_tick = 1'b1; rd_strobe = pop;
    @(negedge clk); os_tick = 1'b0; rd_strobe = 1'b0;
  endtask

  task automatic send_frame(input logic [8:0] w, input logic nine, input logic stop_lvl,
                            input int gbit, input int gtick, input logic pop_at_stop);
    int nb;
    nb = nine ? 9 : 8;
    nine_bit_mode = nine;
    for (int t = 1; t <= 2; t++) slot(1'b1, 1'b0);
    for (int t = 1; t <= 16; t++) slot(1'b0, 1'b0);
    for (int b = 0; b < nb; b++)
      for (int t = 1; t <= 16; t++)
        slot((b == gbit && t == gtick) ? ~w[b] : w[b], 1'b0);
    for (int t = 1; t <= 16; t++) slot(stop_lvl, (t == 9) && pop_at_stop);
  endtask

  task automatic model_pop();
    if (m_cnt > 0) begin
      m_data[0] = m_data[1]; m_b8[0] = m_b8[1]; m_fe[0] = m_fe[1];
      m_cnt--;
    end
  endtask

  task automatic model_push(input logic [8:0] w, input logic nine, input logic stop_lvl);
    if (m_ovr) return;
    if (m_cnt == 2) begin m_ovr = 1'b1; return; end
    m_data[m_cnt] = exp_data(w);
    m_b8[m_cnt]   = exp_b8(w, nine);
    m_fe[m_cnt]   = ~stop_lvl;
    m_cnt++;
  endtask

  task automatic check_status(input string tag);
    chk(data_avail == (m_cnt != 0), {tag, " avail"}, data_avail, m_cnt != 0);
    chk(overrun == m_ovr, {tag, " overrun"}, overrun, m_ovr);
  endtask

  task automatic read_word(input string tag);
    chk(data_avail == 1'b1, {tag, " avail before read"}, data_avail, 1);
    chk(rd_data == m_data[0], {tag, " data"}, rd_data, m_data[0]);
    chk(rd_bit8 == m_b8[0], {tag, " bit8"}, rd_bit8, m_b8[0]);
    chk(rd_frame_err == m_fe[0], {tag, " ferr"}, rd_frame_err, m_fe[0]);
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
    model_pop();
  endtask

  task automatic cycle_enable();
    @(negedge clk); rx_enable = 1'b0;
    @(negedge clk); @(negedge clk);
    rx_enable = 1'b1;
    m_ovr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int rnd;
    rst_n = 1'b0; rx_line = 1'b1; rx_enable = 1'b0; nine_bit_mode = 1'b0;
    rd_strobe = 1'b0; os_tick = 1'b0;
    rnd = $urandom(32'h1A2B);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(data_avail == 0, "R1 reset avail", data_avail, 0);
    chk(overrun == 0, "R1 reset overrun", overrun, 0);
    rx_enable = 1'b1;

    // R2: 8-bit frame, LSB first
    send_frame(9'h0A5, 1'b0, 1'b1, -1, 0, 1'b0); model_push(9'h0A5, 1'b0, 1'b1);
    check_status("R2");
    read_word("R2 8-bit word");
    // R3: 9-bit frame with ninth bit set
    send_frame(9'h13C, 1'b1, 1'b1, -1, 0, 1'b0); model_push(9'h13C, 1'b1, 1'b1);
    read_word("R3 ninth bit");
    // R4: one flipped sample at each of ticks 7, 8, 9
    send_frame(9'h0F0, 1'b0, 1'b1, 0, 7, 1'b0); model_push(9'h0F0, 1'b0, 1'b1);
    read_word("R4 flip tick7");
    send_frame(9'h055, 1'b0, 1'b1, 3, 8, 1'b0); model_push(9'h055, 1'b0, 1'b1);
    read_word("R4 flip tick8");
    send_frame(9'h1AA, 1'b1, 1'b1, 8, 9, 1'b0); model_push(9'h1AA, 1'b1, 1'b1);
    read_word("R4 flip tick9");
    // R5: short start glitch rejected
    for (int t = 1; t <= 2; t++) slot(1'b1, 1'b0);
    for (int t = 1; t <= 5; t++) slot(1'b0, 1'b0);
    for (int t = 1; t <= 200; t++) slot(1'b1, 1'b0);
    check_status("R5 glitch ignored");
    send_frame(9'h081, 1'b0, 1'b1, -1, 0, 1'b0); model_push(9'h081, 1'b0, 1'b1);
    read_word("R5 frame after glitch");
    // R6 + R7: framing flags travel with their words, order kept
    send_frame(9'h011, 1'b0, 1'b0, -1, 0, 1'b0); model_push(9'h011, 1'b0, 1'b0);
    send_frame(9'h122, 1'b1, 1'b1, -1, 0, 1'b0); model_push(9'h122, 1'b1, 1'b1);
    check_status("R7 two held");
    read_word("R6 ferr word one");
    read_word("R7 second word");
    check_status("R7 empty after reads");
    // R8 + R9: overrun
    send_frame(9'h031, 1'b0, 1'b1, -1, 0, 1'b0); model_push(9'h031, 1'b0, 1'b1);
    send_frame(9'h032, 1'b0, 1'b1, -1, 0, 1'b0); model_push(9'h032, 1'b0, 1'b1);
    send_frame(9'h033, 1'b0, 1'b1, -1, 0, 1'b0); model_push(9'h033, 1'b0, 1'b1);
    check_status("R8 overrun set");
    read_word("R8 first kept");
    send_frame(9'h034, 1'b0, 1'b1, -1, 0, 1'b0); model_push(9'h034, 1'b0, 1'b1);
    read_word("R9 second kept");
    check_status("R9 blocked while overrun");
    // R10: enable low clears overrun and ignores the line; buffer kept
    send_frame(9'h035, 1'b0, 1'b1, -1, 0, 1'b0); model_push(9'h035, 1'b0, 1'b1);
    @(negedge clk); rx_enable = 1'b0;
    send_frame(9'h0EE, 1'b0, 1'b1, -1, 0, 1'b0);
    m_ovr = 1'b0;
    check_status("R10 disabled");
    rx_enable = 1'b1;
    // R10: mid-frame drop resets frame logic
    for (int t = 1; t <= 40; t++) slot(1'b0, 1'b0);
    cycle_enable();
    for (int t = 1; t <= 20; t++) slot(1'b1, 1'b0);
    check_status("R10 mid-frame reset");
    send_frame(9'h047, 1'b0, 1'b1, -1, 0, 1'b0); model_push(9'h047, 1'b0, 1'b1);
    check_status("R10 after reenable");
    // R11: read in the completion cycle with a full buffer
    send_frame(9'h151, 1'b1, 1'b1, -1, 0, 1'b0); model_push(9'h151, 1'b1, 1'b1);
    send_frame(9'h062, 1'b0, 1'b0, -1, 0, 1'b1); model_pop(); model_push(9'h062, 1'b0, 1'b0);
    check_status("R11 same-cycle read");
    read_word("R11 older word");
    read_word("R11 newer word");

    // random frames
    for (int i = 0; i < 30; i++) begin
      logic [8:0] w;
      logic       nine, stp;
      int         gb, gt, nrd;
      w    = 9'($urandom);
      nine = 1'($urandom % 2);
      stp  = ($urandom % 5) != 0;
      gb   = $urandom % 8;
      gt   = 1 + ($urandom % 16);
      send_frame(w, nine, stp, gb, gt, 1'b0);
      model_push(w, nine, stp);
      check_status("R8 random status");
      if (m_ovr) begin
        while (m_cnt > 0) read_word("R9 random drain");
        cycle_enable();
        check_status("R10 random clear");
      end else begin
        nrd = $urandom % (m_cnt + 1);
        for (int k = 0; k < nrd; k++) read_word("R2 random read");
      end
    end
    while (m_cnt > 0) read_word("R7 final drain");
    check_status("R7 final");
    finish_run();
  end

endmodule